// File: doc/BRIEF.md
# Multiplexed BCD Display Scanner

This block drives a time-multiplexed display of three and a half decimal digits for the result of a converter. It keeps one latched copy of the result: a half digit that is 0 or 1, three full BCD digits and an overrange flag. It shows that copy one digit at a time. Four active-high digit selects take turns, starting with the half digit and ending with the least significant digit. While a digit is selected, its code sits on a shared 4-bit bus. Each digit slot lasts 80 clocks. The first 2 clocks of a slot are a blanking gap with every select low, and the bus takes the new digit's code at the start of that gap so that it has settled before the select rises.

The scan is tied to the converter's rhythm. An end-of-conversion pulse restarts the scan at the half digit, even in the middle of a slot. A new result is copied into the latches only on a rising edge of the display-update input, and only while the ramp-down level input is low. Tying the update input to the end-of-conversion pulse therefore shows every result, starting in the very slot that the pulse opens. The overrange output is active low: it is high normally and low while the latched result is over range.

The scanner is a three-state machine. IDLE holds every select low until the first end-of-conversion. BLANK runs the gap clocks of a slot. SHOW drives one select for the rest of the slot. The named transitions are: *start* (any state to BLANK on end-of-conversion, digit index set to the half digit), *open* (BLANK to SHOW when the last gap clock has run), and *advance* (SHOW to BLANK at the end of a slot, with the index moving to the next lower digit and wrapping from the least significant digit back to the half digit).

Top module: `bcd_disp_scan`

## Requirements
- R1: After reset, and for as long as no end-of-conversion pulse arrives, `dsel` is 4'b0000, `bcd` is 0 and `ovr_n` is 1.
- R2: The clock edge that samples `eoc_pulse` high starts a slot for the half digit. `dsel` stays 0 for the next two cycles and is 4'b1000 in the third.
- R3: Slots follow the order `dsel[3]` (half digit), `dsel[2]`, `dsel[1]`, `dsel[0]`, then wrap back to `dsel[3]`. A select never changes to another select without passing through blanking.
- R4: Every slot is 80 clocks long: 2 clocks with `dsel` = 0, then 78 clocks with that slot's select high.
- R5: At most one bit of `dsel` is high in any cycle.
- R6: During the whole of a slot, blanking included, `bcd` carries that slot's latched code: {3'b000, half} for `dsel[3]`, `dig2_in` for `dsel[2]`, `dig1_in` for `dsel[1]` and `dig0_in` for `dsel[0]`.
- R7: The result inputs are latched on the clock edge that samples `upd_in` high after it was low in the previous cycle, provided `ramp_dn` is low. Holding `upd_in` high latches nothing further.
- R8: A rising edge on `upd_in` sampled while `ramp_dn` is high is ignored: the latched digits and `ovr_n` keep their values.
- R9: `ovr_n` is the inverse of the latched overrange flag (0 means over range).
- R10: An end-of-conversion pulse in the middle of a slot abandons that slot and restarts at the half digit, as R2 describes.
- R11: When `eoc_pulse` and an accepted `upd_in` edge are sampled on the same clock edge, the new result is on `bcd` from the first cycle of the half-digit slot that the pulse opens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eoc_pulse | input | 1 | One-clock end-of-conversion pulse |
| upd_in | input | 1 | Display-update strobe; its rising edge latches the result |
| ramp_dn | input | 1 | High while the converter is in ramp-down; blocks latching |
| half_in | input | 1 | Half digit of the new result |
| dig2_in | input | 4 | Most significant full BCD digit of the new result |
| dig1_in | input | 4 | Middle BCD digit of the new result |
| dig0_in | input | 4 | Least significant BCD digit of the new result |
| ovr_in | input | 1 | New result is over range when 1 |
| dsel | output | 4 | Active-high digit selects; bit 3 is the half digit |
| bcd | output | 4 | Shared BCD bus carrying the selected digit's code |
| ovr_n | output | 1 | Active-low overrange indication |

## Verification
A scan restart and a data latch can land on the same clock edge. This is the normal case when the update input is tied to the end-of-conversion pulse. The bench provokes it by raising both inputs in one cycle for a sweep of result patterns. It then walks the next five slots clock by clock and compares `dsel` and `bcd` with values computed from the slot arithmetic, so stale data in the first gap cycle counts as a failure. Separate runs hold the update level high, raise it during ramp-down, and fire an end-of-conversion pulse partway through a slot, to check that the latch and the scan stay independent.

// File: rtl/bcd_scan_pkg.sv
package bcd_scan_pkg;
    localparam int NUM_DIGITS = 4;
    localparam int DIGIT_W    = 4;
    localparam int IDX_W      = $clog2(NUM_DIGITS);

    typedef enum logic [1:0] {
        SCAN_IDLE,
        SCAN_BLANK,
        SCAN_SHOW
    } scan_state_t;
endpackage

// File: rtl/bcd_update_latch.sv
module bcd_update_latch
    import bcd_scan_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          upd_in,
    input  logic                          ramp_dn,
    input  logic                          half_in,
    input  logic [DIGIT_W-1:0]            dig2_in,
    input  logic [DIGIT_W-1:0]            dig1_in,
    input  logic [DIGIT_W-1:0]            dig0_in,
    input  logic                          ovr_in,
    output logic [NUM_DIGITS*DIGIT_W-1:0] lat_codes,
    output logic                          lat_ovr
);
    logic upd_prev;
    logic take;

    assign take = upd_in && !upd_prev && !ramp_dn;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_prev  <= 1'b0;
            lat_codes <= '0;
            lat_ovr   <= 1'b0;
        end else begin
            upd_prev <= upd_in;
            if (take) begin
                lat_codes <= {{(DIGIT_W-1){1'b0}}, half_in, dig2_in, dig1_in, dig0_in};
                lat_ovr   <= ovr_in;
            end
        end
    end
endmodule

// File: rtl/bcd_scan_fsm.sv
module bcd_scan_fsm
    import bcd_scan_pkg::*;
#(
    parameter int SLOT_CLKS = 80,
    parameter int GAP_CLKS  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eoc_pulse,
    output scan_state_t       state,
    output logic [IDX_W-1:0]  dig_idx
);
    localparam int CNT_W = $clog2(SLOT_CLKS);
    localparam logic [CNT_W-1:0] GAP_LAST  = CNT_W'(GAP_CLKS - 1);
    localparam logic [CNT_W-1:0] SLOT_LAST = CNT_W'(SLOT_CLKS - 1);
    localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(NUM_DIGITS - 1);

    scan_state_t       state_nxt;
    logic [CNT_W-1:0]  cnt, cnt_nxt;
    logic [IDX_W-1:0]  idx_nxt;

    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        idx_nxt   = dig_idx;
        if (eoc_pulse) begin
            state_nxt = SCAN_BLANK;        // start
            cnt_nxt   = '0;
            idx_nxt   = '0;
        end else begin
            unique case (state)
                SCAN_IDLE: ;
                SCAN_BLANK: begin
                    cnt_nxt = cnt + 1'b1;
                    if (cnt == GAP_LAST)
                        state_nxt = SCAN_SHOW; // open
                end
                SCAN_SHOW: begin
                    if (cnt == SLOT_LAST) begin
                        state_nxt = SCAN_BLANK; // advance
                        cnt_nxt   = '0;
                        idx_nxt   = (dig_idx == IDX_LAST) ? '0 : dig_idx + 1'b1;
                    end else begin
                        cnt_nxt = cnt + 1'b1;
                    end
                end
                default: state_nxt = SCAN_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SCAN_IDLE;
            cnt     <= '0;
            dig_idx <= '0;
        end else begin
            state   <= state_nxt;
            cnt     <= cnt_nxt;
            dig_idx <= idx_nxt;
        end
    end
endmodule

// File: rtl/bcd_digit_out.sv
module bcd_digit_out
    import bcd_scan_pkg::*;
(
    input  scan_state_t                   state,
    input  logic [IDX_W-1:0]              dig_idx,
    input  logic [NUM_DIGITS*DIGIT_W-1:0] lat_codes,
    output logic [NUM_DIGITS-1:0]         dsel,
    output logic [DIGIT_W-1:0]            bcd
);
    logic [NUM_DIGITS-1:0] hit;

    for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_sel
        assign hit[NUM_DIGITS-1-i] = (dig_idx == IDX_W'(i));
    end

    always_comb begin
        dsel = '0;
        bcd  = '0;
        unique case (state)
            SCAN_IDLE: ;
            SCAN_BLANK: bcd = lat_codes[(NUM_DIGITS-1-int'(dig_idx))*DIGIT_W +: DIGIT_W];
            SCAN_SHOW: begin
                bcd  = lat_codes[(NUM_DIGITS-1-int'(dig_idx))*DIGIT_W +: DIGIT_W];
                dsel = hit;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/bcd_disp_scan.sv
module bcd_disp_scan
    import bcd_scan_pkg::*;
#(
    parameter int SLOT_CLKS = 80,
    parameter int GAP_CLKS  = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  eoc_pulse,
    input  logic                  upd_in,
    input  logic                  ramp_dn,
    input  logic                  half_in,
    input  logic [3:0]            dig2_in,
    input  logic [3:0]            dig1_in,
    input  logic [3:0]            dig0_in,
    input  logic                  ovr_in,
    output logic [3:0]            dsel,
    output logic [3:0]            bcd,
    output logic                  ovr_n
);
    scan_state_t                   state;
    logic [IDX_W-1:0]              dig_idx;
    logic [NUM_DIGITS*DIGIT_W-1:0] lat_codes;
    logic                          lat_ovr;

    bcd_update_latch i_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_in    (upd_in),
        .ramp_dn   (ramp_dn),
        .half_in   (half_in),
        .dig2_in   (dig2_in),
        .dig1_in   (dig1_in),
        .dig0_in   (dig0_in),
        .ovr_in    (ovr_in),
        .lat_codes (lat_codes),
        .lat_ovr   (lat_ovr)
    );

    bcd_scan_fsm #(
        .SLOT_CLKS (SLOT_CLKS),
        .GAP_CLKS  (GAP_CLKS)
    ) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .eoc_pulse (eoc_pulse),
        .state     (state),
        .dig_idx   (dig_idx)
    );

    bcd_digit_out i_out (
        .state     (state),
        .dig_idx   (dig_idx),
        .lat_codes (lat_codes),
        .dsel      (dsel),
        .bcd       (bcd)
    );

    assign ovr_n = !lat_ovr;
endmodule

// File: rtl/bcd_disp_scan_chk.sv
module bcd_disp_scan_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       eoc_pulse,
    input logic       ramp_dn,
    input logic [3:0] dsel,
    input logic       ovr_n
);
    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dsel)); // R5

    AST_GAP_BEFORE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (dsel != 4'b0000 && $past(dsel) == 4'b0000) |-> $past(dsel, 2) == 4'b0000); // R4

    AST_NO_DIRECT_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
        (dsel != 4'b0000 && $past(dsel) != 4'b0000) |-> dsel == $past(dsel)); // R3

    AST_EOC_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
        eoc_pulse |=> dsel == 4'b0000); // R10

    AST_EOC_HALF_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(eoc_pulse, 3) && !$past(eoc_pulse, 2) && !$past(eoc_pulse)) |-> dsel == 4'b1000); // R2

    AST_RAMP_HOLDS_OVR: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ramp_dn) |-> $stable(ovr_n)); // R8
endmodule

bind bcd_disp_scan bcd_disp_scan_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .eoc_pulse (eoc_pulse),
    .ramp_dn   (ramp_dn),
    .dsel      (dsel),
    .ovr_n     (ovr_n)
);

// File: tb/test_bcd_disp_scan.sv
module test_bcd_disp_scan;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       eoc_pulse = 1'b0;
    logic       upd_in = 1'b0;
    logic       ramp_dn = 1'b0;
    logic       half_in = 1'b0;
    logic [3:0] dig2_in = '0, dig1_in = '0, dig0_in = '0;
    logic       ovr_in = 1'b0;
    logic [3:0] dsel, bcd;
    logic       ovr_n;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    bcd_disp_scan i_bcd_disp_scan (
        .clk(clk), .rst_n(rst_n), .eoc_pulse(eoc_pulse), .upd_in(upd_in),
        .ramp_dn(ramp_dn), .half_in(half_in), .dig2_in(dig2_in), .dig1_in(dig1_in),
        .dig0_in(dig0_in), .ovr_in(ovr_in), .dsel(dsel), .bcd(bcd), .ovr_n(ovr_n)
    );

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic set_result(input logic h, input logic [3:0] a, input logic [3:0] b,
                              input logic [3:0] c, input logic o);
        half_in = h; dig2_in = a; dig1_in = b; dig0_in = c; ovr_in = o;
    endtask

    // Called at a negedge; raises eoc (and upd when asked) for one edge.
    // Returns at the negedge right after that edge, i.e. slot position 0.
    task automatic fire(input bit with_upd, input bit keep_upd);
        eoc_pulse = 1'b1;
        if (with_upd) upd_in = 1'b1;
        @(negedge clk);
        eoc_pulse = 1'b0;
        if (with_upd && !keep_upd) upd_in = 1'b0;
    endtask

    // Walk ncyc cycles from slot position 0, checking R2, R3, R4, R6.
    task automatic walk(input int ncyc, input logic [3:0] c0, input logic [3:0] c1,
                        input logic [3:0] c2, input logic [3:0] c3, input string tag);
        for (int k = 0; k < ncyc; k++) begin
            int pos  = k % 80;
            int slot = (k / 80) % 4;
            logic [3:0] e_sel = (pos < 2) ? 4'b0000 : (4'b1000 >> slot);
            logic [3:0] e_bcd = (slot == 0) ? c0 : (slot == 1) ? c1 : (slot == 2) ? c2 : c3;
            chk({tag, " R4/R3/R2 dsel"}, dsel, e_sel);
            chk({tag, " R6 bcd"}, bcd, e_bcd);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state holds while no eoc arrives
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            chk("R1 dsel idle", dsel, 4'b0000);
        end
        chk("R1 bcd idle", bcd, 4'h0);
        chk("R1 ovr_n idle", {3'b000, ovr_n}, 4'h1);

        // R11/R9 sweep: eoc and update on the same edge, 5 slots walked
        for (int p = 0; p < 10; p++) begin
            logic h = p[0];
            logic [3:0] a = 4'(p);
            logic [3:0] b = 4'((p + 3) % 10);
            logic [3:0] c = 4'(9 - p);
            logic o = (p % 3 == 0);
            set_result(h, a, b, c, o);
            fire(1'b1, 1'b0);
            chk("R11 first gap shows new half", bcd, {3'b000, h});
            chk("R9 ovr_n", {3'b000, ovr_n}, {3'b000, !o});
            walk(400, {3'b000, h}, a, b, c, "R11 sweep");
        end

        // R7: held update level latches once only
        set_result(1'b1, 4'd4, 4'd5, 4'd6, 1'b0);
        fire(1'b1, 1'b1);
        walk(320, 4'd1, 4'd4, 4'd5, 4'd6, "R7 first latch");
        set_result(1'b0, 4'd7, 4'd8, 4'd9, 1'b1);
        fire(1'b0, 1'b0);
        walk(320, 4'd1, 4'd4, 4'd5, 4'd6, "R7 level held");
        chk("R7 ovr_n unchanged by level", {3'b000, ovr_n}, 4'h1);
        upd_in = 1'b0;
        @(negedge clk);
        fire(1'b1, 1'b0);
        walk(320, 4'd0, 4'd7, 4'd8, 4'd9, "R7 new edge");
        chk("R7/R9 ovr_n after edge", {3'b000, ovr_n}, 4'h0);

        // R8: edge during ramp-down ignored
        ramp_dn = 1'b1;
        set_result(1'b1, 4'd2, 4'd3, 4'd1, 1'b0);
        fire(1'b1, 1'b0);
        ramp_dn = 1'b0;
        walk(320, 4'd0, 4'd7, 4'd8, 4'd9, "R8 ramp ignore");
        chk("R8 ovr_n held", {3'b000, ovr_n}, 4'h0);

        // R10: eoc mid-slot restarts at the half digit
        fire(1'b0, 1'b0);
        walk(150, 4'd0, 4'd7, 4'd8, 4'd9, "R10 pre");
        fire(1'b0, 1'b0);
        walk(240, 4'd0, 4'd7, 4'd8, 4'd9, "R10 restart");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule